// File: doc/BRIEF.md
# Split-Half Page Map Fill Walker

This block refills a translation buffer after a miss under a one-level paging scheme. Each map word in memory is 36 bits wide and holds the entries of two neighbouring virtual pages, one in each 18-bit half. The requester supplies the faulting virtual address, the table the miss belongs to (user or executive), the access type, and the page numbers of the executive and user process tables. The walker then works out which map word to fetch and issues a single physical read for it. When the data returns it picks the correct half and checks the access rights.

A permitted access makes the walker emit an expanded entry for the buffer, holding a valid bit, a modifiable bit and the physical page number. Otherwise it raises a page fail and supplies a composed status word. The user map is one contiguous region of the user process table. The executive map is spread over three page-number ranges. The lowest and highest ranges live in the executive process table, each at its own offset. The middle range lives in the user process table.

A read reported as non-existent memory ends the walk as a hard fault that carries the physical map-word address. The interface uses a start pulse, a busy level and a one-cycle done pulse. At most one memory read is outstanding.

Top module: `pagemap_walker`

## Requirements
- R1: For a user-table miss, the map word address is upt_ppn*512 + USR_MAP_OFS (default 0) + vpn/2, where vpn = vaddr[17:9].
- R2: For an executive miss with vpn below EXM_START (default octal 340), the address is ept_ppn*512 + EXL_MAP_OFS (default octal 600) + vpn/2.
- R3: For an executive miss with EXM_START <= vpn < EXH_START (default octal 400), the address is upt_ppn*512 + EXM_MAP_OFS (default octal 400) + (vpn-EXM_START)/2.
- R4: For an executive miss with vpn >= EXH_START, the address is ept_ppn*512 + EXH_MAP_OFS (default octal 200) + (vpn-EXH_START)/2.
- R5: An even vpn uses bits 35:18 of the returned word and an odd vpn uses bits 17:0. Within a half, bit 17 means accessible, bit 16 writable and bit 15 software, and bits 10:0 hold the physical page number.
- R6: Access is granted when the accessible bit is set and the reference is a read or the writable bit is set. On a grant, fill_we pulses with fill_entry = {1 (valid, bit 12), writable (bit 11), page number (bits 10:0)}. fill_vpn and fill_user carry the request.
- R7: A denied access pulses fault with a fault_word holding bit 35 = user table, bit 33 = 1 (virtual fault), bit 32 = write, and bits 17:0 = vaddr. Bits 31 (accessible) and 30 (software bit of the half) are set only when the accessible bit was set. All other bits are zero.
- R8: A read answered with rd_nxm pulses fault and never fill_we. The fault_word then holds bit 35 = user table, bit 34 = 1 (non-existent memory) and bits 19:0 = map word address. All other bits, including bit 33, are zero.
- R9: Each walk issues exactly one single-cycle rd_req and ends with one single-cycle done that comes with exactly one of fill_we or fault. A start pulse while busy is ignored.
- R10: During and after reset, busy, rd_req, done, fill_we and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| vaddr | input | 18 | Faulting virtual address |
| user_tbl | input | 1 | 1 = user table miss, 0 = executive |
| is_write | input | 1 | 1 = write reference |
| ept_ppn | input | 11 | Executive process table page number |
| upt_ppn | input | 11 | User process table page number |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | 20 | Physical map word address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 36 | Map word |
| rd_nxm | input | 1 | Read hit non-existent memory |
| done | output | 1 | Walk finished, one cycle |
| fill_we | output | 1 | Write expanded entry to the buffer |
| fill_user | output | 1 | Table of the entry |
| fill_vpn | output | 9 | Virtual page of the entry |
| fill_entry | output | 13 | {valid, modifiable, physical page} |
| fault | output | 1 | Page fail |
| fault_word | output | 36 | Page fail status word |

## Verification
Misses are driven for pages on each side of both executive range boundaries (octal 337/340 and 377/400) and for user pages. Comparing the requested address against the formulas separates the three executive placements from the user one. Words whose two halves carry opposite rights are fetched for an even and an odd page, which exposes a swapped half select. Reads, writes to writable and read-only pages, entries with and without the accessible bit, and a non-existent-memory reply separate the grant rule and the optional fault-word bits. A start pulse during a pending read checks that the latched request and the single read survive.

// File: rtl/pmw_pkg.sv
`timescale 1ns/1ps
package pmw_pkg;
  localparam int HALF_W  = 18;
  localparam int WORD_W  = 36;
  // map entry half-word bit positions
  localparam int PTE_ACC = 17;
  localparam int PTE_WRT = 16;
  localparam int PTE_SFT = 15;
  localparam int PTE_CCH = 14;
  // page fail status word bit positions
  localparam int FW_USER  = 35;
  localparam int FW_NXM   = 34;
  localparam int FW_VIRT  = 33;
  localparam int FW_WRITE = 32;
  localparam int FW_ACC   = 31;
  localparam int FW_SFT   = 30;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} walk_st_t;
endpackage

// File: rtl/pmw_addr_gen.sv
`timescale 1ns/1ps
module pmw_addr_gen #(
  parameter int VPN_W       = 9,
  parameter int PG_W        = 9,
  parameter int PPN_W       = 11,
  parameter int USR_MAP_OFS = 0,
  parameter int EXL_MAP_OFS = 'o600,
  parameter int EXM_MAP_OFS = 'o400,
  parameter int EXH_MAP_OFS = 'o200,
  parameter int EXM_START   = 'o340,
  parameter int EXH_START   = 'o400
) (
  input  logic [VPN_W-1:0]      vpn,
  input  logic                  user_tbl,
  input  logic [PPN_W-1:0]      ept_ppn,
  input  logic [PPN_W-1:0]      upt_ppn,
  output logic [PPN_W+PG_W-1:0] map_addr
);
  localparam int PA_W = PPN_W + PG_W;
  localparam logic [PA_W-1:0]  USR_V  = PA_W'(USR_MAP_OFS);
  localparam logic [PA_W-1:0]  EXL_V  = PA_W'(EXL_MAP_OFS);
  localparam logic [PA_W-1:0]  EXM_V  = PA_W'(EXM_MAP_OFS);
  localparam logic [PA_W-1:0]  EXH_V  = PA_W'(EXH_MAP_OFS);
  localparam logic [VPN_W-1:0] MID_LO = VPN_W'(EXM_START);
  localparam logic [VPN_W-1:0] HI_LO  = VPN_W'(EXH_START);

  logic [PA_W-1:0]  ebase, ubase, base, ofs;
  logic [VPN_W-1:0] rel;

  always_comb begin
    ebase = {ept_ppn, {PG_W{1'b0}}};
    ubase = {upt_ppn, {PG_W{1'b0}}};
    if (user_tbl) begin
      base = ubase; ofs = USR_V; rel = vpn;
    end else if (vpn < MID_LO) begin
      base = ebase; ofs = EXL_V; rel = vpn;
    end else if (vpn < HI_LO) begin
      base = ubase; ofs = EXM_V; rel = vpn - MID_LO;
    end else begin
      base = ebase; ofs = EXH_V; rel = vpn - HI_LO;
    end
    map_addr = base + ofs + PA_W'(rel >> 1);
  end
endmodule

// File: rtl/pmw_pte_check.sv
`timescale 1ns/1ps
module pmw_pte_check
  import pmw_pkg::*;
#(
  parameter int VADDR_W = 18,
  parameter int PPN_W   = 11,
  parameter int PA_W    = 20
) (
  input  logic [WORD_W-1:0]  word,
  input  logic               odd_page,
  input  logic               is_write,
  input  logic               user_tbl,
  input  logic               nxm,
  input  logic [VADDR_W-1:0] vaddr,
  input  logic [PA_W-1:0]    map_addr,
  output logic               grant,
  output logic [PPN_W+1:0]   entry,
  output logic [WORD_W-1:0]  fword
);
  logic [HALF_W-1:0] half;
  logic acc, wrt, sft;
  logic unused_pte_bits;

  always_comb begin
    half  = odd_page ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    acc   = half[PTE_ACC];
    wrt   = half[PTE_WRT];
    sft   = half[PTE_SFT];
    grant = !nxm && acc && (!is_write || wrt);
    entry = {1'b1, wrt, half[PPN_W-1:0]};
    fword = '0;
    fword[FW_USER] = user_tbl;
    if (nxm) begin
      fword[FW_NXM]     = 1'b1;
      fword[PA_W-1:0]   = map_addr;
    end else begin
      fword[FW_VIRT]      = 1'b1;
      fword[FW_WRITE]     = is_write;
      fword[VADDR_W-1:0]  = vaddr;
      if (acc) begin
        fword[FW_ACC] = 1'b1;
        fword[FW_SFT] = sft;
      end
    end
  end

  assign unused_pte_bits = ^half[PTE_CCH:PPN_W];
endmodule

// File: rtl/pmw_ctrl.sv
`timescale 1ns/1ps
module pmw_ctrl
  import pmw_pkg::*;
#(
  parameter int VADDR_W = 18,
  parameter int PPN_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VADDR_W-1:0] in_vaddr,
  input  logic               in_user,
  input  logic               in_wr,
  input  logic [PPN_W-1:0]   in_ept,
  input  logic [PPN_W-1:0]   in_upt,
  input  logic               rd_ack,
  input  logic               chk_grant,
  input  logic [PPN_W+1:0]   chk_entry,
  input  logic [WORD_W-1:0]  chk_fword,
  output logic               busy,
  output logic               rd_req,
  output logic [VADDR_W-1:0] req_vaddr,
  output logic               req_user,
  output logic               req_wr,
  output logic [PPN_W-1:0]   req_ept,
  output logic [PPN_W-1:0]   req_upt,
  output logic               done,
  output logic               fill_we,
  output logic [PPN_W+1:0]   fill_entry,
  output logic               fault,
  output logic [WORD_W-1:0]  fault_word
);
  localparam int ENT_W = PPN_W + 2;

  walk_st_t st_q, st_n;
  logic latch_en;
  logic done_n, fill_n, fault_n;
  logic [ENT_W-1:0]  entry_n;
  logic [WORD_W-1:0] fword_n;

  // next state
  always_comb begin
    st_n     = st_q;
    latch_en = 1'b0;
    done_n   = 1'b0;
    fill_n   = 1'b0;
    fault_n  = 1'b0;
    entry_n  = fill_entry;
    fword_n  = fault_word;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n     = ST_REQ;
        latch_en = 1'b1;
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: if (rd_ack) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
        if (chk_grant) begin
          fill_n  = 1'b1;
          entry_n = chk_entry;
        end else begin
          fault_n = 1'b1;
          fword_n = chk_fword;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // state and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      done       <= 1'b0;
      fill_we    <= 1'b0;
      fault      <= 1'b0;
      fill_entry <= '0;
      fault_word <= '0;
    end else begin
      st_q       <= st_n;
      done       <= done_n;
      fill_we    <= fill_n;
      fault      <= fault_n;
      fill_entry <= entry_n;
      fault_word <= fword_n;
    end
  end

  // request capture, enabled on accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vaddr <= '0;
      req_user  <= 1'b0;
      req_wr    <= 1'b0;
      req_ept   <= '0;
      req_upt   <= '0;
    end else if (latch_en) begin
      req_vaddr <= in_vaddr;
      req_user  <= in_user;
      req_wr    <= in_wr;
      req_ept   <= in_ept;
      req_upt   <= in_upt;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign rd_req = (st_q == ST_REQ);

  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(req_vaddr));
  // R9
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (st_q == ST_WAIT));
  // R6
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (fill_entry[ENT_W-1] && done));
  // R8
  nxm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_word[FW_NXM]) |-> (!fault_word[FW_VIRT] && !fill_we));
endmodule

// File: rtl/pagemap_walker.sv
`timescale 1ns/1ps
module pagemap_walker
  import pmw_pkg::*;
#(
  parameter int VADDR_W     = 18,
  parameter int VPN_W       = 9,
  parameter int PPN_W       = 11,
  parameter int USR_MAP_OFS = 0,
  parameter int EXL_MAP_OFS = 'o600,
  parameter int EXM_MAP_OFS = 'o400,
  parameter int EXH_MAP_OFS = 'o200,
  parameter int EXM_START   = 'o340,
  parameter int EXH_START   = 'o400
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [VADDR_W-1:0]                vaddr,
  input  logic                              user_tbl,
  input  logic                              is_write,
  input  logic [PPN_W-1:0]                  ept_ppn,
  input  logic [PPN_W-1:0]                  upt_ppn,
  output logic                              busy,
  output logic                              rd_req,
  output logic [PPN_W+VADDR_W-VPN_W-1:0]    rd_addr,
  input  logic                              rd_ack,
  input  logic [35:0]                       rd_data,
  input  logic                              rd_nxm,
  output logic                              done,
  output logic                              fill_we,
  output logic                              fill_user,
  output logic [VPN_W-1:0]                  fill_vpn,
  output logic [PPN_W+1:0]                  fill_entry,
  output logic                              fault,
  output logic [35:0]                       fault_word
);
  localparam int PG_W = VADDR_W - VPN_W;
  localparam int PA_W = PPN_W + PG_W;

  logic [VADDR_W-1:0] req_vaddr;
  logic               req_user, req_wr;
  logic [PPN_W-1:0]   req_ept, req_upt;
  logic               chk_grant;
  logic [PPN_W+1:0]   chk_entry;
  logic [WORD_W-1:0]  chk_fword;
  logic [VPN_W-1:0]   req_vpn;

  assign req_vpn   = req_vaddr[VADDR_W-1:PG_W];
  assign fill_vpn  = req_vpn;
  assign fill_user = req_user;

  pmw_ctrl #(.VADDR_W(VADDR_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_vaddr(vaddr), .in_user(user_tbl), .in_wr(is_write),
    .in_ept(ept_ppn), .in_upt(upt_ppn), .rd_ack(rd_ack),
    .chk_grant(chk_grant), .chk_entry(chk_entry), .chk_fword(chk_fword),
    .busy(busy), .rd_req(rd_req),
    .req_vaddr(req_vaddr), .req_user(req_user), .req_wr(req_wr),
    .req_ept(req_ept), .req_upt(req_upt),
    .done(done), .fill_we(fill_we), .fill_entry(fill_entry),
    .fault(fault), .fault_word(fault_word)
  );

  pmw_addr_gen #(
    .VPN_W(VPN_W), .PG_W(PG_W), .PPN_W(PPN_W),
    .USR_MAP_OFS(USR_MAP_OFS), .EXL_MAP_OFS(EXL_MAP_OFS),
    .EXM_MAP_OFS(EXM_MAP_OFS), .EXH_MAP_OFS(EXH_MAP_OFS),
    .EXM_START(EXM_START), .EXH_START(EXH_START)
  ) u_addr (
    .vpn(req_vpn), .user_tbl(req_user),
    .ept_ppn(req_ept), .upt_ppn(req_upt), .map_addr(rd_addr)
  );

  pmw_pte_check #(.VADDR_W(VADDR_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_check (
    .word(rd_data), .odd_page(req_vpn[0]), .is_write(req_wr),
    .user_tbl(req_user), .nxm(rd_nxm), .vaddr(req_vaddr),
    .map_addr(rd_addr), .grant(chk_grant), .entry(chk_entry),
    .fword(chk_fword)
  );
endmodule

// File: tb/pagemap_walker_bench.sv
`timescale 1ns/1ps
module pagemap_walker_bench;
  localparam int T_USR = 0;
  localparam int T_LO  = 'o600;
  localparam int T_MID = 'o400;
  localparam int T_HI  = 'o200;

  typedef struct packed {
    logic [17:0] vaddr;
    logic        user;
    logic        wr;
    logic [10:0] ept;
    logic [10:0] upt;
    logic [35:0] word;
    logic        nxm;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{18'o005123, 1'b1, 1'b0, 11'o12,   11'o47, 36'o001111_601234, 1'b0, 2'd0},
    '{18'o000777, 1'b1, 1'b1, 11'o12,   11'o47, 36'o501777_600002, 1'b0, 2'd1},
    '{18'o337000, 1'b0, 1'b0, 11'o12,   11'o47, 36'o000005_403210, 1'b0, 2'd2},
    '{18'o340400, 1'b0, 1'b1, 11'o3,    11'o70, 36'o602222_000000, 1'b0, 2'd0},
    '{18'o377777, 1'b0, 1'b0, 11'o12,   11'o47, 36'o777777_001111, 1'b0, 2'd1},
    '{18'o400001, 1'b0, 1'b0, 11'o12,   11'o47, 36'o400123_000000, 1'b0, 2'd0},
    '{18'o777000, 1'b0, 1'b1, 11'o1777, 11'o47, 36'o000000_700444, 1'b0, 2'd3},
    '{18'o123456, 1'b1, 1'b0, 11'o12,   11'o47, 36'o0,             1'b1, 2'd1},
    '{18'o000100, 1'b0, 1'b1, 11'o12,   11'o47, 36'o601000_400777, 1'b0, 2'd0},
    '{18'o001100, 1'b0, 1'b1, 11'o12,   11'o47, 36'o601000_400777, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] vaddr = '0;
  logic        user_tbl = 1'b0;
  logic        is_write = 1'b0;
  logic [10:0] ept_ppn = '0;
  logic [10:0] upt_ppn = '0;
  logic        rd_ack = 1'b0;
  logic [35:0] rd_data = '0;
  logic        rd_nxm = 1'b0;
  logic        busy, rd_req, done, fill_we, fill_user, fault;
  logic [19:0] rd_addr;
  logic [8:0]  fill_vpn;
  logic [12:0] fill_entry;
  logic [35:0] fault_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pagemap_walker #(
    .USR_MAP_OFS(T_USR), .EXL_MAP_OFS(T_LO),
    .EXM_MAP_OFS(T_MID), .EXH_MAP_OFS(T_HI)
  ) u_pagemap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
    .user_tbl(user_tbl), .is_write(is_write), .ept_ppn(ept_ppn),
    .upt_ppn(upt_ppn), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_nxm(rd_nxm), .done(done),
    .fill_we(fill_we), .fill_user(fill_user), .fill_vpn(fill_vpn),
    .fill_entry(fill_entry), .fault(fault), .fault_word(fault_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input vec_t v);
    logic [8:0]  p;
    logic [19:0] eb, ub;
    p  = v.vaddr[17:9];
    eb = {v.ept, 9'd0};
    ub = {v.upt, 9'd0};
    if (v.user)            return ub + 20'(T_USR) + 20'(p / 2);
    else if (p < 9'o340)   return eb + 20'(T_LO)  + 20'(p / 2);
    else if (p < 9'o400)   return ub + 20'(T_MID) + 20'((p - 9'o340) / 2);
    else                   return eb + 20'(T_HI)  + 20'((p - 9'o400) / 2);
  endfunction

  function automatic string addr_tag(input vec_t v);
    if (v.user) return "R1 user map address";
    else if (v.vaddr[17:9] < 9'o340) return "R2 exec low address";
    else if (v.vaddr[17:9] < 9'o400) return "R3 exec middle address";
    else return "R4 exec high address";
  endfunction

  task automatic run_vec(input vec_t v);
    logic [17:0] h;
    logic        grant;
    logic [35:0] fw;
    int k;
    @(negedge clk);
    vaddr = v.vaddr; user_tbl = v.user; is_write = v.wr;
    ept_ppn = v.ept; upt_ppn = v.upt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!rd_req && k < 20) begin @(negedge clk); k++; end
    chk("R9 read request issued", 64'(rd_req), 64'd1);
    chk(addr_tag(v), 64'(rd_addr), 64'(exp_addr(v)));
    @(negedge clk);
    chk("R9 single-cycle read request", 64'(rd_req), 64'd0);
    repeat (v.lat) @(negedge clk);
    rd_ack = 1'b1; rd_data = v.word; rd_nxm = v.nxm;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = '0; rd_nxm = 1'b0;
    h = v.vaddr[9] ? v.word[17:0] : v.word[35:18];
    grant = !v.nxm && h[17] && (!v.wr || h[16]);
    chk("R9 done pulse", 64'(done), 64'd1);
    if (v.nxm) begin
      fw = '0; fw[35] = v.user; fw[34] = 1'b1; fw[19:0] = exp_addr(v);
      chk("R8 nxm fault", 64'({fill_we, fault}), 64'b01);
      chk("R8 nxm fault word", 64'(fault_word), 64'(fw));
    end else if (grant) begin
      chk("R6 fill strobe", 64'({fill_we, fault}), 64'b10);
      chk("R5 R6 fill entry", 64'(fill_entry), 64'({1'b1, h[16], h[10:0]}));
      chk("R6 fill vpn and table", 64'({fill_user, fill_vpn}), 64'({v.user, v.vaddr[17:9]}));
    end else begin
      fw = '0; fw[35] = v.user; fw[33] = 1'b1; fw[32] = v.wr; fw[17:0] = v.vaddr;
      if (h[17]) begin fw[31] = 1'b1; fw[30] = h[15]; end
      chk("R7 access fault", 64'({fill_we, fault}), 64'b01);
      chk("R5 R7 fault word", 64'(fault_word), 64'(fw));
    end
    @(negedge clk);
    chk("R9 done ends", 64'({done, busy, fill_we, fault}), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t w;
    repeat (3) @(negedge clk);
    chk("R10 outputs in reset", 64'({busy, rd_req, done, fill_we, fault}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 outputs after reset", 64'({busy, rd_req, done, fill_we, fault}), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: start while a read is pending is ignored
    w = VECS[0];
    @(negedge clk);
    vaddr = w.vaddr; user_tbl = w.user; is_write = w.wr;
    ept_ppn = w.ept; upt_ppn = w.upt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 request before overlap", 64'(rd_req), 64'd1);
    @(negedge clk);
    vaddr = 18'o777000; user_tbl = 1'b0; is_write = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no second request while busy", 64'({busy, rd_req}), 64'b10);
    chk("R9 address kept while busy", 64'(rd_addr), 64'(exp_addr(w)));
    rd_ack = 1'b1; rd_data = w.word; rd_nxm = 1'b0;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = '0;
    chk("R9 first request completes", 64'({done, fill_we, fill_user, fill_vpn}),
        64'({1'b1, 1'b1, 1'b1, 9'o005}));
    repeat (2) @(negedge clk);
    chk("R9 ignored start left no walk", 64'({busy, rd_req, done}), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule